// File: doc/BRIEF.md
# Shifted Saturation Unit

This block clamps a 32-bit operand into a range chosen by a saturate-position immediate. It also reports whether any clamping took place, by setting a sticky bit in a status word that the caller supplies. It serves four operations. Two work on the whole word: signed and unsigned saturation. Two work on a pair of halfword lanes: signed and unsigned saturation of each lane on its own.

For the whole-word forms, the operand first goes through an immediate shifter, either logical left or arithmetic right, and the shifted value is then clamped. For the dual forms, each 16-bit lane is sign-extended and clamped on its own, with no shift, and each result returns to its own lane.

The datapath is combinational and feeds an output register that loads only while the enable is high, so a failed condition leaves both the result and the status word untouched. Decode, register-file access and condition evaluation stay with the caller.

Top module: `shsat_unit`

## Requirements
- R1: Opcode encoding: 0 is signed word saturation, 1 is unsigned word, 2 is signed dual halfword, 3 is unsigned dual halfword. In the word forms the operand is first shifted by `shamt_i`. Shift type 0 shifts logically left by 0 to 31 places, and bits that leave the top are lost.
- R2: Shift type 2 is an arithmetic right shift. A shift amount of 0 with this type shifts by 32, so the value becomes all copies of bit 31.
- R3: Signed word saturation with position n clamps the shifted value to the range -2^(n-1) to 2^(n-1)-1. The legal positions are 1 to 32. A position of 0 acts as 1, and a position above 32 acts as 32.
- R4: Unsigned word saturation with position n clamps the shifted value (read as signed) to the range 0 to 2^n-1, so negative values become 0. The legal positions are 0 to 31, and a position above 31 acts as 31.
- R5: When any clamping occurs, the status output is the status input with bit 27 set. With no clamping, the status input passes through unchanged. The block never clears bit 27, and it never alters the other bits.
- R6: In the dual forms, bits 15:0 and bits 31:16 are each sign-extended from 16 bits and clamped on their own. The signed form uses positions 1 to 16 (0 acts as 1, above 16 acts as 16). The unsigned form uses positions 0 to 15 (above 15 acts as 15). The shift inputs are ignored. Bit 27 is set if either lane clamps.
- R7: The result and the status word appear on the outputs one clock after a cycle in which `en_i` is high. While `en_i` is low, both outputs hold their values.
- R8: After reset, `result_o` and `flags_o` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Condition passed; loads the output register |
| op_i | input | 2 | Operation select (R1 encoding) |
| shtype_i | input | 2 | Shift type: 0 logical left, 2 arithmetic right |
| shamt_i | input | 5 | Immediate shift amount |
| satpos_i | input | 6 | Saturate-position immediate |
| operand_i | input | 32 | Source operand |
| flags_i | input | 32 | Current status word |
| result_o | output | 32 | Saturated result |
| flags_o | output | 32 | Updated status word |

## Verification
The hardest cases to reach are the edges of the position and shift encodings. One is a position at or beyond its legal limit, which must act as the limit. Another is an arithmetic-right amount of 0, which means a full 32-place shift. A third is a dual operation where only one lane overflows but the flag must still rise. Directed operands are chosen to sit exactly at, one past and far beyond each clamp bound, for both lanes separately and for both polarities of the incoming sticky bit. A few hundred random operations then cover the remaining combinations, checked against an arithmetic model that works in 64-bit integers.

// File: rtl/shsat_pkg.sv
package shsat_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LANE_W   = DATA_W / 2;
  localparam int unsigned POS_W    = 6;
  localparam int unsigned AMT_W    = $clog2(DATA_W);
  localparam int unsigned FLAG_BIT = 27;

  typedef enum logic [1:0] {
    OP_SWORD = 2'd0,
    OP_UWORD = 2'd1,
    OP_SDUAL = 2'd2,
    OP_UDUAL = 2'd3
  } shsat_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              sat;
  } shsat_out_t;
endpackage

// File: rtl/shsat_shifter.sv
module shsat_shifter #(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     val_i,
  input  logic             asr_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     val_o
);
  always_comb begin
    if (asr_i) begin
      if (amt_i == '0) val_o = {W{val_i[W-1]}};
      else             val_o = W'($signed(val_i) >>> amt_i);
    end else begin
      val_o = val_i << amt_i;
    end
  end
endmodule

// File: rtl/shsat_clamp.sv
module shsat_clamp #(
  parameter int unsigned W     = 32,
  parameter int unsigned POS_W = 6
) (
  input  logic [W-1:0]     val_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             uns_i,
  output logic [W-1:0]     res_o,
  output logic             sat_o
);
  localparam int unsigned SH_W = $clog2(W + 1);

  logic [SH_W-1:0]  pos_eff;
  logic [SH_W-1:0]  sh;
  logic [W:0]       one_sh;
  logic signed [W:0] vx, hi, lo;

  always_comb begin
    // legalize the position to the range of this variant
    if (uns_i) begin
      if (32'(pos_i) > W - 1) pos_eff = SH_W'(W - 1);
      else                    pos_eff = SH_W'(pos_i);
    end else begin
      if (pos_i == '0)        pos_eff = SH_W'(1);
      else if (32'(pos_i) > W) pos_eff = SH_W'(W);
      else                    pos_eff = SH_W'(pos_i);
    end
    sh     = uns_i ? pos_eff : pos_eff - SH_W'(1);
    one_sh = {{W{1'b0}}, 1'b1} << sh;
    vx     = $signed({val_i[W-1], val_i});
    hi     = $signed(one_sh - {{W{1'b0}}, 1'b1});
    lo     = uns_i ? '0 : -$signed(one_sh);
    if (vx > hi) begin
      res_o = hi[W-1:0];
      sat_o = 1'b1;
    end else if (vx < lo) begin
      res_o = lo[W-1:0];
      sat_o = 1'b1;
    end else begin
      res_o = val_i;
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/shsat_unit.sv
module shsat_unit
  import shsat_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic [1:0]  op_i,
  input  logic [1:0]  shtype_i,
  input  logic [4:0]  shamt_i,
  input  logic [5:0]  satpos_i,
  input  logic [31:0] operand_i,
  input  logic [31:0] flags_i,
  output logic [31:0] result_o,
  output logic [31:0] flags_o
);
  localparam int unsigned NLANE = DATA_W / LANE_W;

  logic              is_uns, is_dual;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] word_res;
  logic              word_sat;
  logic [DATA_W-1:0] dual_res;
  logic [NLANE-1:0]  lane_sat;
  shsat_out_t        nxt;
  logic [DATA_W-1:0] flags_nxt;

  assign is_uns  = op_i[0];
  assign is_dual = op_i[1];

  shsat_shifter #(.W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .val_i (operand_i),
    .asr_i (shtype_i[1]),
    .amt_i (shamt_i),
    .val_o (shifted)
  );

  shsat_clamp #(.W(DATA_W), .POS_W(POS_W)) u_word (
    .val_i (shifted),
    .pos_i (satpos_i),
    .uns_i (is_uns),
    .res_o (word_res),
    .sat_o (word_sat)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    shsat_clamp #(.W(LANE_W), .POS_W(POS_W)) u_lane (
      .val_i (operand_i[g*LANE_W +: LANE_W]),
      .pos_i (satpos_i),
      .uns_i (is_uns),
      .res_o (dual_res[g*LANE_W +: LANE_W]),
      .sat_o (lane_sat[g])
    );
  end

  always_comb begin
    if (is_dual) begin
      nxt.res = dual_res;
      nxt.sat = |lane_sat;
    end else begin
      nxt.res = word_res;
      nxt.sat = word_sat;
    end
    flags_nxt = flags_i;
    if (nxt.sat) flags_nxt[FLAG_BIT] = 1'b1;
  end

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] res_q, flg_q;
    logic [DATA_W-1:0] res_d, flg_d;

    always_comb begin
      res_d = res_q;
      flg_d = flg_q;
      if (en_i) begin
        res_d = nxt.res;
        flg_d = flags_nxt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        flg_q <= '0;
      end else begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end

    assign result_o = res_q;
    assign flags_o  = flg_q;
  end else begin : g_comb
    assign result_o = nxt.res;
    assign flags_o  = en_i ? flags_nxt : flags_i;
  end
endmodule

// File: rtl/shsat_unit_chk.sv
module shsat_unit_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en_i,
  input logic [1:0]  op_i,
  input logic [5:0]  satpos_i,
  input logic [31:0] flags_i,
  input logic [31:0] result_o,
  input logic [31:0] flags_o
);
  localparam logic [31:0] STICKY = 32'h0800_0000;

  if (REG_OUT) begin : g_chk
    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> ($stable(result_o) && $stable(flags_o)));

    // R5
    sticky_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && flags_i[27]) |=> flags_o[27]);

    // R5
    other_bits_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> ((flags_o & ~STICKY) == ($past(flags_i) & ~STICKY)));

    // R4
    uword_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 2'd1) |=> !result_o[31]);

    // R6
    udual_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 2'd3) |=> (!result_o[31] && !result_o[15]));

    // R3
    full_width_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 2'd0 && satpos_i >= 6'd32) |=> (flags_o[27] == $past(flags_i[27])));
  end
endmodule

bind shsat_unit shsat_unit_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .op_i     (op_i),
  .satpos_i (satpos_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/shsat_unit_tb_top.sv
`timescale 1ns/100ps
module shsat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [1:0]  op_i;
  logic [1:0]  shtype_i;
  logic [4:0]  shamt_i;
  logic [5:0]  satpos_i;
  logic [31:0] operand_i;
  logic [31:0] flags_i;
  logic [31:0] result_o;
  logic [31:0] flags_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic [31:0] flg;
  } exp_t;
  exp_t scb[$];

  logic [31:0] mdl_res = '0;
  logic [31:0] mdl_flg = '0;

  always #2.5 clk = ~clk;

  shsat_unit dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .shtype_i(shtype_i),
    .shamt_i(shamt_i), .satpos_i(satpos_i), .operand_i(operand_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic void clampv(input longint v, input bit uns, input int n,
                                 output longint r, output bit s);
    longint hi, lo;
    if (uns) begin hi = (64'sd1 <<< n) - 1; lo = 0; end
    else begin hi = (64'sd1 <<< (n - 1)) - 1; lo = -(64'sd1 <<< (n - 1)); end
    s = 1'b1;
    if (v > hi)      r = hi;
    else if (v < lo) r = lo;
    else begin r = v; s = 1'b0; end
  endfunction

  function automatic void model(input logic [1:0] op, input logic [1:0] st,
                                input logic [4:0] am, input logic [5:0] ps,
                                input logic [31:0] x, output logic [31:0] r,
                                output bit s);
    longint v, o0, o1;
    bit s0, s1;
    int n;
    if (!op[1]) begin
      if (st[1]) v = longint'($signed(x)) >>> ((am == 0) ? 32 : int'(am));
      else begin
        logic [31:0] t;
        t = x << am;
        v = longint'($signed(t));
      end
      if (op[0]) n = (ps > 31) ? 31 : int'(ps);
      else       n = (ps == 0) ? 1 : ((ps > 32) ? 32 : int'(ps));
      clampv(v, op[0], n, o0, s);
      r = o0[31:0];
    end else begin
      if (op[0]) n = (ps > 15) ? 15 : int'(ps);
      else       n = (ps == 0) ? 1 : ((ps > 16) ? 16 : int'(ps));
      clampv(longint'($signed(x[15:0])), op[0], n, o0, s0);
      clampv(longint'($signed(x[31:16])), op[0], n, o1, s1);
      r = {o1[15:0], o0[15:0]};
      s = s0 | s1;
    end
  endfunction

  task automatic drive(input string tag, input bit en, input logic [1:0] op,
                       input logic [1:0] st, input logic [4:0] am,
                       input logic [5:0] ps, input logic [31:0] x,
                       input logic [31:0] f);
    logic [31:0] r;
    bit s;
    exp_t e;
    @(negedge clk);
    en_i = en; op_i = op; shtype_i = st; shamt_i = am;
    satpos_i = ps; operand_i = x; flags_i = f;
    if (en) begin
      model(op, st, am, ps, x, r, s);
      mdl_res = r;
      mdl_flg = s ? (f | 32'h0800_0000) : f;
    end
    e.tag = tag; e.res = mdl_res; e.flg = mdl_flg;
    scb.push_back(e);
  endtask

  // monitor: outputs are registered, compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        n_run++;
        if (result_o !== e.res || flags_o !== e.flg) begin
          n_fail++;
          $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                   e.tag, result_o, flags_o, e.res, e.flg);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_i = 1'b0; op_i = '0; shtype_i = '0; shamt_i = '0;
    satpos_i = '0; operand_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    n_run++;
    if (result_o !== 32'h0 || flags_o !== 32'h0) begin
      n_fail++;
      $display("FAIL R8 reset: result=%h flags=%h expected 0/0", result_o, flags_o);
    end
    rst_n = 1'b1;

    // R1 logical left then signed clamp: 0x1000<<4 = 0x10000 -> 0x7FFF
    drive("R1 lsl sat", 1, 2'd0, 2'd0, 5'd4, 6'd16, 32'h0000_1000, 32'h0000_0005);
    drive("R1 lsl fits", 1, 2'd0, 2'd0, 5'd3, 6'd16, 32'h0000_0100, 32'h0000_0000);
    // R2 arithmetic right: amount 0 means 32
    drive("R2 asr32 neg", 1, 2'd0, 2'd2, 5'd0, 6'd8, 32'h8000_0000, 32'h0);
    drive("R2 asr32 pos", 1, 2'd0, 2'd2, 5'd0, 6'd8, 32'h7FFF_FFFF, 32'h0);
    drive("R2 asr4", 1, 2'd0, 2'd2, 5'd4, 6'd9, 32'h0000_0F00, 32'h0);
    // R3 signed bounds
    drive("R3 neg clamp", 1, 2'd0, 2'd0, 5'd0, 6'd8, 32'hFFFF_FC18, 32'h0);
    drive("R3 at min", 1, 2'd0, 2'd0, 5'd0, 6'd8, 32'hFFFF_FF80, 32'h0);
    drive("R3 one past max", 1, 2'd0, 2'd0, 5'd0, 6'd8, 32'h0000_0080, 32'h0);
    drive("R3 pos32 free", 1, 2'd0, 2'd0, 5'd0, 6'd32, 32'h7FFF_FFFF, 32'h0);
    drive("R3 pos40 as 32", 1, 2'd0, 2'd0, 5'd0, 6'd40, 32'h8000_0000, 32'h0);
    drive("R3 pos0 as 1", 1, 2'd0, 2'd0, 5'd0, 6'd0, 32'h0000_0005, 32'h0);
    // R4 unsigned bounds
    drive("R4 neg to zero", 1, 2'd1, 2'd0, 5'd0, 6'd8, 32'hFFFF_FFFB, 32'h0);
    drive("R4 over max", 1, 2'd1, 2'd0, 5'd0, 6'd8, 32'h0000_012C, 32'h0);
    drive("R4 inside", 1, 2'd1, 2'd0, 5'd0, 6'd8, 32'h0000_00C8, 32'h0);
    drive("R4 pos0", 1, 2'd1, 2'd0, 5'd0, 6'd0, 32'h0000_0001, 32'h0);
    drive("R4 pos63 as 31", 1, 2'd1, 2'd0, 5'd0, 6'd63, 32'h7FFF_FFFF, 32'h0);
    // R5 sticky flag and pass-through
    drive("R5 kept no sat", 1, 2'd0, 2'd0, 5'd0, 6'd16, 32'h0000_0010, 32'h0800_1234);
    drive("R5 set other bits", 1, 2'd1, 2'd0, 5'd0, 6'd4, 32'h0000_0100, 32'hA000_00FF);
    drive("R5 clear in stays", 1, 2'd0, 2'd0, 5'd0, 6'd16, 32'h0000_0010, 32'hF7FF_FFFF);
    // R6 dual lanes
    drive("R6 both lanes", 1, 2'd2, 2'd2, 5'd7, 6'd8, 32'h7FFF_8000, 32'h0);
    drive("R6 upper only", 1, 2'd2, 2'd0, 5'd0, 6'd8, 32'h0100_0010, 32'h0);
    drive("R6 lower only", 1, 2'd2, 2'd0, 5'd0, 6'd8, 32'h0010_FF00, 32'h0);
    drive("R6 unsigned", 1, 2'd3, 2'd0, 5'd0, 6'd4, 32'hFFF0_0100, 32'h0);
    drive("R6 none", 1, 2'd3, 2'd0, 5'd0, 6'd20, 32'h1234_0042, 32'h0);
    drive("R6 pos0 as 1", 1, 2'd2, 2'd0, 5'd0, 6'd0, 32'hFFFF_0003, 32'h0);
    // R7 enable low holds
    drive("R7 load", 1, 2'd0, 2'd0, 5'd0, 6'd16, 32'h0000_0033, 32'h0000_0001);
    drive("R7 hold", 0, 2'd1, 2'd0, 5'd0, 6'd2, 32'hFFFF_FFFF, 32'h0000_0000);
    drive("R7 hold2", 0, 2'd2, 2'd0, 5'd0, 6'd1, 32'h7FFF_7FFF, 32'hFFFF_FFFF);
    // random sweep
    for (int i = 0; i < 300; i++) begin
      drive("R1 random", ($urandom_range(0, 7) != 0), 2'($urandom()),
            {1'($urandom()), 1'b0}, 5'($urandom()), 6'($urandom_range(0, 40)),
            $urandom(), $urandom());
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule